// File: doc/BRIEF.md
# Sponge Hash Command Sequencer

This block is the control core of a register-driven SHA3 / SHAKE / cSHAKE hashing engine. Software writes one-shot command pulses (start, process, run, done) and the sequencer walks the engine through its idle, absorb and squeeze phases. It issues permutation requests to an external Keccak core and waits for that core's completion pulse. It waits for the message path to report that it has drained before it asks for the final-block permutation.

The sequencer also owns the engine configuration word. That word can only be written while the engine is idle. When start is issued, the sequencer checks that the chosen strength and mode form a legal pair. While a hash is in progress it blocks key writes and reports an error for each one. Completion and error events are signalled as one-cycle interrupt pulses, and a 32-bit error code records the first cause of trouble.

Top module: `sponge_cmd_seq`

## Requirements
- R1: After reset the status word is 3'b001, the config write enable is 1, the config word is 0, no permutation is requested, both interrupts are low and the error code is 0.
- R2: The status word is always one-hot: bit 0 means idle, bit 1 means absorb (from an accepted start until the final permutation completes), and bit 2 means squeeze (including run permutations).
- R3: The command bits are bit 0 start, bit 1 process, bit 2 run and bit 3 done. A legal start in idle enters absorb on the next cycle. The config word is laid out as strength in bits [2:0], mode in bits [4:3] (0 SHA3, 1 reserved, 2 SHAKE, 3 cSHAKE) and keyed enable in bit 5. In cSHAKE mode the sequencer first requests a prefix permutation (kind 0). When keyed is set it then requests a key permutation (kind 1). Only after these does it accept message data.
- R4: A command issued outside its phase has no effect on the status word or on the permutation request.
- R5: Process in absorb asserts no permutation request until msg_drained is high. It then requests the final permutation (kind 2). On completion of that permutation the status word shows squeeze and irq_done pulses for one cycle.
- R6: Run in squeeze requests a permutation of kind 3. Every permutation request and its kind stay steady until perm_done. On completion the status word returns to squeeze and irq_done pulses for one cycle.
- R7: Done in squeeze returns the engine to idle on the next cycle. Done is ignored while a run permutation is in flight.
- R8: The config write enable equals the idle status bit. A config write while it is 0 leaves the config word unchanged. A config write while it is 1 stores the data.
- R9: SHA3 mode accepts strength codes 0 to 4. SHAKE and cSHAKE accept only codes 0 and 2. The reserved mode accepts none.
- R10: A start with an illegal pair keeps the engine idle, pulses irq_err for one cycle and sets the error code to 1.
- R11: A key write while not idle is blocked (key_accept is 0), pulses irq_err and records error code 2. A key write in idle passes through with no error.
- R12: The error code keeps its first nonzero cause until the next start in idle. That start clears it, or sets it to 1 if the start is itself illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 4 | Command pulses: start, process, run, done |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 6 | Config write data |
| key_we | input | 1 | Key write attempt |
| msg_drained | input | 1 | Message path has emptied |
| perm_done | input | 1 | Permutation core completion pulse |
| cfg_q | output | 6 | Current config word |
| cfg_wen | output | 1 | Config write enable |
| key_accept | output | 1 | Gated key write strobe |
| perm_req | output | 1 | Permutation request, held until done |
| perm_kind | output | 2 | Request kind: prefix, key, final, run |
| status | output | 3 | Phase flags: idle, absorb, squeeze |
| irq_done | output | 1 | Completion pulse |
| irq_err | output | 1 | Error pulse |
| err_code | output | 32 | First error cause |

## Verification
The assertions take for granted that perm_done is pulsed only while a permutation request is up. They also take for granted that command bits arrive as single-cycle pulses. The stimulus keeps to this: the bench raises perm_done for exactly one cycle and only after it has seen perm_req high. Each command is driven for exactly one cycle and then cleared. Out-of-phase commands are still driven deliberately, one at a time, so that the ignore behaviour is observed at the status and request outputs.

// File: rtl/sponge_seq_pkg.sv
// Shared types and constants for the sponge command sequencer.
// Assumes: command bits and config layout are fixed by the register map.
package sponge_seq_pkg;
    localparam int CMD_W  = 4;
    localparam int CFG_W  = 6;
    localparam int STR_W  = 3;
    localparam int KIND_W = 2;
    localparam int STAT_W = 3;

    localparam int CMD_START = 0;
    localparam int CMD_PROC  = 1;
    localparam int CMD_RUN   = 2;
    localparam int CMD_DONE  = 3;

    localparam int ERR_BAD_CFG  = 1;
    localparam int ERR_KEY_BUSY = 2;

    typedef enum logic [1:0] {
        MODE_SHA3  = 2'd0,
        MODE_RSVD  = 2'd1,
        MODE_SHAKE = 2'd2,
        MODE_CSHK  = 2'd3
    } mode_e;

    typedef struct packed {
        logic             keyed;
        mode_e            mode;
        logic [STR_W-1:0] strength;
    } cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PRE, PH_KEY, PH_ABS, PH_DRAIN, PH_FINAL, PH_SQZ, PH_RUN
    } phase_e;

    typedef enum logic [KIND_W-1:0] {
        PK_PREFIX = 2'd0,
        PK_KEY    = 2'd1,
        PK_FINAL  = 2'd2,
        PK_RUN    = 2'd3
    } pkind_e;
endpackage

// File: rtl/seq_cfg_guard.sv
// Holds the engine configuration word, locks it outside idle and judges
// whether the strength/mode pair is legal.
// Assumes: idle comes from the phase machine's registered state.
module seq_cfg_guard
    import sponge_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cfg_t             cfg_q,
    output logic             cfg_wen,
    output logic             cfg_legal
);
    localparam logic [STR_W-1:0] STR_MAX = 3'd4;

    assign cfg_wen = idle;

    // Store a config write only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we && cfg_wen)
            cfg_q <= cfg_t'(cfg_wdata);
    end

    // Legality of the current strength/mode pair.
    always_comb begin
        case (cfg_q.mode)
            MODE_SHA3:             cfg_legal = (cfg_q.strength <= STR_MAX);
            MODE_SHAKE, MODE_CSHK: cfg_legal = (cfg_q.strength == 3'd0) ||
                                               (cfg_q.strength == 3'd2);
            default:               cfg_legal = 1'b0;
        endcase
    end

    // R8
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wen) |=> $stable(cfg_q));
endmodule

// File: rtl/seq_phase_fsm.sv
// Phase machine: steps idle -> (prefix) -> (key) -> absorb -> drain ->
// final -> squeeze, with optional run permutations, and back to idle.
// Assumes: perm_done pulses only while perm_req is high.
module seq_phase_fsm
    import sponge_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              cfg_legal,
    input  logic              use_prefix,
    input  logic              use_key,
    input  logic              msg_drained,
    input  logic              perm_done,
    output logic              perm_req,
    output logic [KIND_W-1:0] perm_kind,
    output logic [STAT_W-1:0] status,
    output logic              irq_done,
    output logic              start_seen,
    output logic              bad_start
);
    phase_e ph_q, ph_d;

    assign start_seen = (ph_q == PH_IDLE) && cmd[CMD_START];
    assign bad_start  = start_seen && !cfg_legal;

    // Next-phase selection from commands and handshakes.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE:  if (start_seen && cfg_legal)
                          ph_d = use_prefix ? PH_PRE : (use_key ? PH_KEY : PH_ABS);
            PH_PRE:   if (perm_done) ph_d = use_key ? PH_KEY : PH_ABS;
            PH_KEY:   if (perm_done) ph_d = PH_ABS;
            PH_ABS:   if (cmd[CMD_PROC]) ph_d = PH_DRAIN;
            PH_DRAIN: if (msg_drained) ph_d = PH_FINAL;
            PH_FINAL: if (perm_done) ph_d = PH_SQZ;
            PH_SQZ:   if (cmd[CMD_DONE]) ph_d = PH_IDLE;
                      else if (cmd[CMD_RUN]) ph_d = PH_RUN;
            PH_RUN:   if (perm_done) ph_d = PH_SQZ;
            default:  ph_d = PH_IDLE;
        endcase
    end

    // Phase register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            irq_done <= 1'b0;
        end else begin
            ph_q     <= ph_d;
            irq_done <= perm_done && (ph_q == PH_FINAL || ph_q == PH_RUN);
        end
    end

    // Permutation request and kind decoded from the phase.
    always_comb begin
        perm_req  = 1'b1;
        perm_kind = PK_PREFIX;
        case (ph_q)
            PH_PRE:   perm_kind = PK_PREFIX;
            PH_KEY:   perm_kind = PK_KEY;
            PH_FINAL: perm_kind = PK_FINAL;
            PH_RUN:   perm_kind = PK_RUN;
            default:  perm_req  = 1'b0;
        endcase
    end

    // Status flags grouped by phase.
    always_comb begin
        status    = '0;
        status[0] = (ph_q == PH_IDLE);
        status[1] = (ph_q == PH_PRE) || (ph_q == PH_KEY) || (ph_q == PH_ABS) ||
                    (ph_q == PH_DRAIN) || (ph_q == PH_FINAL);
        status[2] = (ph_q == PH_SQZ) || (ph_q == PH_RUN);
    end

    // R2
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status) == 1);
    // R6
    perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_req && !perm_done) |=> (perm_req && $stable(perm_kind)));
    // R10
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_start |=> status[0]);
    // R5
    done_in_sqz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> status[2]);
endmodule

// File: rtl/seq_err_track.sv
// Error pulse and first-cause error code; cleared by a start in idle.
// Assumes: start_seen and key_busy are never high in the same cycle.
module seq_err_track
    import sponge_seq_pkg::*;
#(
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_seen,
    input  logic             bad_start,
    input  logic             key_busy,
    output logic             irq_err,
    output logic [ERR_W-1:0] err_code
);
    localparam logic [ERR_W-1:0] CODE_CFG = ERR_W'(ERR_BAD_CFG);
    localparam logic [ERR_W-1:0] CODE_KEY = ERR_W'(ERR_KEY_BUSY);

    // Capture the first cause and raise a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_code <= '0;
            irq_err  <= 1'b0;
        end else begin
            irq_err <= bad_start || key_busy;
            if (start_seen)
                err_code <= bad_start ? CODE_CFG : '0;
            else if (key_busy && err_code == '0)
                err_code <= CODE_KEY;
        end
    end

    // R11
    key_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_busy |=> irq_err);
    // R12
    first_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != '0 && !start_seen) |=> $stable(err_code));
endmodule

// File: rtl/sponge_cmd_seq.sv
// Top of the sponge hash command sequencer: joins config guard, phase
// machine and error tracker, and gates key writes to idle.
// Assumes: the permutation core and message path sit outside this block.
module sponge_cmd_seq
    import sponge_seq_pkg::*;
#(
    parameter int ERR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              key_we,
    input  logic              msg_drained,
    input  logic              perm_done,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              cfg_wen,
    output logic              key_accept,
    output logic              perm_req,
    output logic [KIND_W-1:0] perm_kind,
    output logic [STAT_W-1:0] status,
    output logic              irq_done,
    output logic              irq_err,
    output logic [ERR_W-1:0]  err_code
);
    cfg_t cfg_s;
    logic legal_s, start_s, bad_s, key_busy_s;

    assign cfg_q      = cfg_s;
    assign key_accept = key_we && status[0];
    assign key_busy_s = key_we && !status[0];

    seq_cfg_guard u_cfg (
        .clk(clk), .rst_n(rst_n), .idle(status[0]),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_s), .cfg_wen(cfg_wen), .cfg_legal(legal_s)
    );

    seq_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cfg_legal(legal_s),
        .use_prefix(cfg_s.mode == MODE_CSHK), .use_key(cfg_s.keyed),
        .msg_drained(msg_drained), .perm_done(perm_done),
        .perm_req(perm_req), .perm_kind(perm_kind), .status(status),
        .irq_done(irq_done), .start_seen(start_s), .bad_start(bad_s)
    );

    seq_err_track #(.ERR_W(ERR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .start_seen(start_s), .bad_start(bad_s),
        .key_busy(key_busy_s), .irq_err(irq_err), .err_code(err_code)
    );

    // R11
    key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_accept |-> status[0]);
endmodule

// File: tb/sim_sponge_cmd_seq.sv
`timescale 1ns/1ps
// Directed bench for the sponge command sequencer, one task per scenario.
module sim_sponge_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic        key_we = 1'b0;
    logic        msg_drained = 1'b0;
    logic        perm_done = 1'b0;
    logic [5:0]  cfg_q;
    logic        cfg_wen, key_accept, perm_req, irq_done, irq_err;
    logic [1:0]  perm_kind;
    logic [2:0]  status;
    logic [31:0] err_code;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sponge_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .key_we(key_we), .msg_drained(msg_drained),
        .perm_done(perm_done), .cfg_q(cfg_q), .cfg_wen(cfg_wen),
        .key_accept(key_accept), .perm_req(perm_req), .perm_kind(perm_kind),
        .status(status), .irq_done(irq_done), .irq_err(irq_err),
        .err_code(err_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_cmd(input int b);
        cmd[b] = 1'b1; tick; cmd = '0;
    endtask

    task automatic write_cfg(input logic [5:0] v);
        cfg_we = 1'b1; cfg_wdata = v; tick; cfg_we = 1'b0;
    endtask

    task automatic pdone;
        perm_done = 1'b1; tick; perm_done = 1'b0;
    endtask

    // From absorb through process, final permutation and done to idle.
    task automatic finish_hash;
        msg_drained = 1'b1;
        pulse_cmd(1); tick;
        chk("R5 final kind", {perm_req, perm_kind}, {1'b1, 2'd2});
        pdone;
        chk("R5 squeeze", status, 3'b100);
        chk("R5 irq_done", irq_done, 1);
        msg_drained = 1'b0;
        pulse_cmd(3);
        chk("R7 idle", status, 3'b001);
    endtask

    task automatic t_reset;
        chk("R1 status", status, 3'b001);
        chk("R1 cfg_wen", cfg_wen, 1);
        chk("R1 cfg_q", cfg_q, 0);
        chk("R1 perm_req", perm_req, 0);
        chk("R1 irqs", {irq_done, irq_err}, 0);
        chk("R1 err_code", err_code, 0);
    endtask

    task automatic t_sha3_flow;
        write_cfg(6'b0_00_100);
        chk("R8 cfg stored", cfg_q, 6'b0_00_100);
        pulse_cmd(0);
        chk("R3 absorb", status, 3'b010);
        chk("R3 no perm", perm_req, 0);
        chk("R8 locked", cfg_wen, 0);
        pulse_cmd(1);
        for (int i = 0; i < 3; i++) begin
            tick;
            chk("R5 wait drain", perm_req, 0);
        end
        msg_drained = 1'b1; tick; msg_drained = 1'b0;
        chk("R5 final kind", {perm_req, perm_kind}, {1'b1, 2'd2});
        pdone;
        chk("R5 squeeze", status, 3'b100);
        chk("R5 irq_done", irq_done, 1);
        tick;
        chk("R5 irq_done one cycle", irq_done, 0);
        pulse_cmd(3);
        chk("R7 done to idle", status, 3'b001);
        chk("R8 unlocked", cfg_wen, 1);
    endtask

    task automatic t_cshake_keyed;
        write_cfg(6'b1_11_010);
        pulse_cmd(0);
        chk("R3 prefix first", {perm_req, perm_kind}, {1'b1, 2'd0});
        chk("R2 absorb bit", status, 3'b010);
        tick; tick;
        chk("R6 prefix held", {perm_req, perm_kind}, {1'b1, 2'd0});
        pdone;
        chk("R3 key second", {perm_req, perm_kind}, {1'b1, 2'd1});
        pdone;
        chk("R3 then absorb", {perm_req, status}, {1'b0, 3'b010});
        finish_hash;
    endtask

    task automatic t_run_done;
        write_cfg(6'b0_10_000);
        pulse_cmd(0);
        msg_drained = 1'b1; pulse_cmd(1); tick; msg_drained = 1'b0;
        pdone;
        chk("R5 in squeeze", status, 3'b100);
        pulse_cmd(2);
        chk("R6 run kind", {perm_req, perm_kind}, {1'b1, 2'd3});
        chk("R2 run is squeeze", status, 3'b100);
        pulse_cmd(3);
        chk("R7 done ignored in run", {perm_req, status}, {1'b1, 3'b100});
        pdone;
        chk("R6 back to squeeze", {perm_req, status}, {1'b0, 3'b100});
        chk("R6 irq_done", irq_done, 1);
        pulse_cmd(3);
        chk("R7 idle", status, 3'b001);
    endtask

    task automatic t_out_of_phase;
        for (int b = 1; b < 4; b++) begin
            pulse_cmd(b);
            chk("R4 idle ignores", {perm_req, status}, {1'b0, 3'b001});
        end
        write_cfg(6'b0_00_000);
        pulse_cmd(0);
        pulse_cmd(0); pulse_cmd(2); pulse_cmd(3);
        chk("R4 absorb ignores", {perm_req, status}, {1'b0, 3'b010});
        msg_drained = 1'b1; pulse_cmd(1); tick; msg_drained = 1'b0;
        pdone;
        pulse_cmd(0); pulse_cmd(1);
        chk("R4 squeeze ignores", {perm_req, status}, {1'b0, 3'b100});
        pulse_cmd(3);
    endtask

    task automatic t_cfg_lock;
        write_cfg(6'b0_00_001);
        pulse_cmd(0);
        write_cfg(6'b1_11_010);
        chk("R8 write discarded", cfg_q, 6'b0_00_001);
        msg_drained = 1'b1; pulse_cmd(1); tick; msg_drained = 1'b0;
        pdone; pulse_cmd(3);
        write_cfg(6'b0_10_010);
        chk("R8 write after idle", cfg_q, 6'b0_10_010);
    endtask

    task automatic t_illegal;
        write_cfg(6'b0_10_001);
        pulse_cmd(0);
        chk("R9 shake 192 rejected", status, 3'b001);
        chk("R10 irq_err", irq_err, 1);
        chk("R10 err_code", err_code, 1);
        tick;
        chk("R10 irq_err one cycle", irq_err, 0);
        write_cfg(6'b0_01_000);
        pulse_cmd(0);
        chk("R9 reserved mode rejected", {irq_err, status}, {1'b1, 3'b001});
        write_cfg(6'b0_00_101);
        pulse_cmd(0);
        chk("R9 sha3 code 5 rejected", {irq_err, status}, {1'b1, 3'b001});
        write_cfg(6'b0_11_000);
        pulse_cmd(0);
        chk("R12 start clears code", err_code, 0);
        chk("R9 cshake 128 legal", {perm_req, perm_kind}, {1'b1, 2'd0});
        pdone;
        key_we = 1'b1; #0.5;
        chk("R11 key blocked", key_accept, 0);
        tick; key_we = 1'b0;
        chk("R11 irq_err", irq_err, 1);
        chk("R11 err_code", err_code, 2);
        key_we = 1'b1; tick; key_we = 1'b0;
        tick;
        chk("R12 first cause held", err_code, 2);
        finish_hash;
        key_we = 1'b1; #0.5;
        chk("R11 key passes in idle", key_accept, 1);
        tick; key_we = 1'b0;
        chk("R11 no error in idle", irq_err, 0);
    endtask

    initial begin
        tick; tick;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_sha3_flow;
        t_cshake_keyed;
        t_run_done;
        t_out_of_phase;
        t_cfg_lock;
        t_illegal;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule